// File: doc/BRIEF.md
# Option-Loaded Watchdog Timer

This block is a watchdog timer whose configuration is loaded while reset is held, from a nonvolatile option byte. Supervision therefore begins on the first clock after reset, before any software has run. The option byte is stored inverted. Its low three bits select the timeout rate. Bit 3 controls the window: a 1 there leaves window mode off. An option value of 0x08 gives rate 7 with window mode off. An option value whose low bits are all ones gives rate 0, which turns the watchdog off.

Software can adjust the configuration through a control write port. The write rules depend on the mode. In normal mode only the first unmasked write after reset is accepted. In special mode every unmasked write is accepted. In both modes the rate and window fields can only move away from their inactive values: a write of rate 0 or of window 0 leaves that field as it is. Such a write is still an accepted write, so in normal mode it uses up the single write.

Software keeps the timer alive through an arm port, by writing 0x55 and then 0xAA. Three things cause a one-cycle timeout pulse: the counter reaching the selected period, a wrong key, or a refresh attempted too early while window mode is on. The period is 2^(rate + PERIOD_BASE) cycles.

Top module: `optload_wdt`

## Requirements
- R1: While `rst` is high, `stat_rate` loads the inverse of `opt_byte[2:0]` and `stat_win` loads the inverse of `opt_byte[3]`. `stat_used` and `wdog_rst` are 0 after reset. For example, `opt_byte` = 0x08 gives rate 7 with window off.
- R2: When `stat_rate` is 0 the watchdog is off. `wdog_rst` never rises, and arm writes have no effect.
- R3: While running, with no arm writes, `wdog_rst` is high for exactly one cycle. That cycle follows the 2^(rate+PERIOD_BASE)-th rising edge counted from reset release, from the last accepted refresh, or from the previous timeout. The count then starts again.
- R4: In normal mode (`special_mode` = 0), only the first write with `ctl_wmask` = 0 after reset is accepted, and it sets `stat_used`. Later control writes change nothing.
- R5: In special mode, every control write with `ctl_wmask` = 0 is accepted.
- R6: A control write with `ctl_wmask` = 1 has no effect. It does not change `stat_rate` or `stat_win`, and it does not set `stat_used`.
- R7: An accepted write copies `ctl_wdata[2:0]` into the rate field when that value is nonzero. A value of 0 leaves the rate unchanged but still counts as the accepted write.
- R8: An accepted write with `ctl_wdata[4]` = 1 turns window mode on. A value of 0 leaves the window bit unchanged but still counts as the accepted write.
- R9: Writing 0xAA to the arm port right after a 0x55 write is a refresh. It restarts the count, provided the window rule of R11 allows it.
- R10: An arm write of any value other than 0x55 or 0xAA raises `wdog_rst` in the next cycle. So does a 0xAA that does not directly follow a 0x55.
- R11: With window mode on, a 0xAA that arrives while the count is below three quarters of the period raises `wdog_rst` in the next cycle. From three quarters of the period onward, the same 0xAA is a refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the option byte is sampled while it is high |
| special_mode | input | 1 | 1 = special mode (repeated control writes allowed) |
| opt_byte | input | 8 | Nonvolatile option byte, stored inverted |
| ctl_we | input | 1 | Control write strobe |
| ctl_wmask | input | 1 | Write mask; 1 blocks the control write |
| ctl_wdata | input | 8 | Control data: [2:0] rate, [4] window enable |
| arm_we | input | 1 | Arm write strobe |
| arm_wdata | input | 8 | Arm key byte |
| wdog_rst | output | 1 | Registered one-cycle timeout reset request |
| stat_rate | output | 3 | Current rate field |
| stat_win | output | 1 | Current window enable |
| stat_used | output | 1 | An accepted control write has occurred since reset |

## Verification
The bench builds the block with PERIOD_BASE = 3. At that value the periods run from 16 cycles (rate 1) to 1024 cycles (rate 7). Every rate can therefore be timed to its exact pulse edge, and the window edge at three quarters of a 32-cycle period can be hit on both sides of the boundary. Random option bytes and random masked or unmasked control writes, in both modes, are checked against a model of the write-once rules.

// File: rtl/optload_wdt_pkg.sv
package optload_wdt_pkg;
  localparam int RATE_W = 3;
  localparam int RATE_MAX = (1 << RATE_W) - 1;
  localparam logic [7:0] KEY_ARM = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam int CTL_WIN_BIT = 4;

  typedef struct packed {
    logic              win;
    logic [RATE_W-1:0] rate;
  } wdt_cfg_t;

  // period of a running rate, in cycles
  function automatic logic [31:0] period_of(input logic [RATE_W-1:0] rate, input int base);
    return 32'd1 << (32'(rate) + base);
  endfunction
endpackage

// File: rtl/optload_wdt_cfg.sv
module optload_wdt_cfg
  import optload_wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       special_mode,
  input  logic [7:0] opt_byte,
  input  logic       we,
  input  logic       wmask,
  input  logic [7:0] wdata,
  output wdt_cfg_t   cfg,
  output logic       used
);
  logic              accept;
  logic [RATE_W-1:0] new_rate;
  logic              unused_bits;

  assign accept   = we && !wmask && (special_mode || !used);
  assign new_rate = wdata[RATE_W-1:0];
  assign unused_bits = ^{opt_byte[7:RATE_W+1], wdata[7:CTL_WIN_BIT+1], wdata[CTL_WIN_BIT-1:RATE_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.rate <= ~opt_byte[RATE_W-1:0];
      cfg.win  <= ~opt_byte[RATE_W];
      used     <= 1'b0;
    end else if (accept) begin
      used <= 1'b1;
      if (new_rate != '0) cfg.rate <= new_rate;
      if (wdata[CTL_WIN_BIT]) cfg.win <= 1'b1;
    end
  end
endmodule

// File: rtl/optload_wdt_key.sv
module optload_wdt_key
  import optload_wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       clr,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       win_ok,
  output logic       refresh,
  output logic       violation
);
  logic seen;
  logic good_fire;

  assign good_fire = (wdata == KEY_FIRE) && seen && win_ok;
  assign refresh   = we && en && good_fire;
  assign violation = we && en && (wdata != KEY_ARM) && !good_fire;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seen <= 1'b0;
    end else if (we && en) begin
      seen <= (wdata == KEY_ARM);
    end
  end
endmodule

// File: rtl/optload_wdt_count.sv
module optload_wdt_count
  import optload_wdt_pkg::*;
#(
  parameter int PERIOD_BASE = 10,
  localparam int CNT_W = RATE_MAX + PERIOD_BASE + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  input  logic              win,
  input  logic              refresh,
  input  logic              violation,
  output logic              win_ok,
  output logic              fire,
  output logic              wdog_rst
);
  logic             en;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] open_at;

  assign en      = (rate != '0);
  assign period  = CNT_W'(period_of(rate, PERIOD_BASE));
  assign last    = period - CNT_W'(1);
  assign open_at = period - (period >> 2);
  assign win_ok  = !win || (cnt >= open_at);
  assign fire    = en && (violation || cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      wdog_rst <= 1'b0;
    end else begin
      wdog_rst <= fire;
      if (!en || fire || refresh) cnt <= '0;
      else                        cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/optload_wdt.sv
module optload_wdt
  import optload_wdt_pkg::*;
#(
  parameter int PERIOD_BASE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              special_mode,
  input  logic [7:0]        opt_byte,
  input  logic              ctl_we,
  input  logic              ctl_wmask,
  input  logic [7:0]        ctl_wdata,
  input  logic              arm_we,
  input  logic [7:0]        arm_wdata,
  output logic              wdog_rst,
  output logic [RATE_W-1:0] stat_rate,
  output logic              stat_win,
  output logic              stat_used
);
  wdt_cfg_t cfg;
  logic     refresh, violation, win_ok, fire;

  optload_wdt_cfg u_cfg (
    .clk(clk), .rst(rst), .special_mode(special_mode), .opt_byte(opt_byte),
    .we(ctl_we), .wmask(ctl_wmask), .wdata(ctl_wdata), .cfg(cfg), .used(stat_used)
  );

  optload_wdt_key u_key (
    .clk(clk), .rst(rst), .en(cfg.rate != '0), .clr(fire), .we(arm_we),
    .wdata(arm_wdata), .win_ok(win_ok), .refresh(refresh), .violation(violation)
  );

  optload_wdt_count #(.PERIOD_BASE(PERIOD_BASE)) u_count (
    .clk(clk), .rst(rst), .rate(cfg.rate), .win(cfg.win), .refresh(refresh),
    .violation(violation), .win_ok(win_ok), .fire(fire), .wdog_rst(wdog_rst)
  );

  assign stat_rate = cfg.rate;
  assign stat_win  = cfg.win;
endmodule

// File: rtl/optload_wdt_chk.sv
module optload_wdt_chk
  import optload_wdt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              special_mode,
  input logic              ctl_we,
  input logic              ctl_wmask,
  input logic              arm_we,
  input logic [7:0]        arm_wdata,
  input logic              wdog_rst,
  input logic [RATE_W-1:0] stat_rate,
  input logic              stat_win,
  input logic              stat_used
);
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    (stat_rate == '0) |=> !wdog_rst); // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stat_used && !special_mode) |=> $stable({stat_rate, stat_win})); // R4
  AST_USED_STICKY: assert property (@(posedge clk) disable iff (rst)
    stat_used |=> stat_used); // R4
  AST_MASK_INERT: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wmask) |=> $stable({stat_rate, stat_win, stat_used})); // R6
  AST_RATE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat_rate != '0) |=> (stat_rate != '0)); // R7
  AST_WIN_STICKY: assert property (@(posedge clk) disable iff (rst)
    stat_win |=> stat_win); // R8
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (rst)
    (arm_we && stat_rate != '0 && arm_wdata != KEY_ARM && arm_wdata != KEY_FIRE) |=> wdog_rst); // R10
endmodule

bind optload_wdt optload_wdt_chk u_chk (.*);

// File: tb/optload_wdt_bench.sv
module optload_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       special_mode = 1'b0;
  logic [7:0] opt_byte = 8'h08;
  logic       ctl_we = 1'b0, ctl_wmask = 1'b0, arm_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00, arm_wdata = 8'h00;
  logic       wdog_rst, stat_win, stat_used;
  logic [2:0] stat_rate;

  int vectors = 0, misses = 0;
  bit done = 0;

  // bench model of the configuration
  int m_rate, m_win, m_used, m_special;

  always #(CLK_PERIOD/2) clk = ~clk;

  optload_wdt #(.PERIOD_BASE(BASE)) u_optload_wdt (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period(input int r);
    return 1 << (r + BASE);
  endfunction

  task automatic do_reset(input logic [7:0] opt, input bit spec);
    @(negedge clk);
    rst = 1; opt_byte = opt; special_mode = spec;
    ctl_we = 0; arm_we = 0;
    @(negedge clk);
    rst = 0;
    m_rate = int'(~opt[2:0]) & 7; m_win = opt[3] ? 0 : 1; m_used = 0; m_special = spec;
  endtask

  task automatic check_cfg(input string req);
    chk(int'(stat_rate) == m_rate, {req, " rate"}, int'(stat_rate), m_rate);
    chk(int'(stat_win) == m_win, {req, " win"}, int'(stat_win), m_win);
    chk(int'(stat_used) == m_used, {req, " used"}, int'(stat_used), m_used);
  endtask

  task automatic ctl_write(input logic [7:0] d, input bit mask);
    ctl_we = 1; ctl_wdata = d; ctl_wmask = mask;
    @(negedge clk);
    ctl_we = 0; ctl_wmask = 0;
    if (!mask && (m_special != 0 || m_used == 0)) begin
      m_used = 1;
      if (d[2:0] != 0) m_rate = int'(d[2:0]);
      if (d[4]) m_win = 1;
    end
  endtask

  task automatic arm_write(input logic [7:0] d);
    arm_we = 1; arm_wdata = d;
    @(negedge clk);
    arm_we = 0;
  endtask

  // counts elapsed edges until the pulse appears
  task automatic edges_to_pulse(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (wdog_rst) break;
    end
  endtask

  initial begin
    int n, seed;
    bit seen;
    seed = $urandom(32'h5eed);

    // R1 reset load, 0x08 case
    do_reset(8'h08, 0);
    chk(stat_rate == 3'd7, "R1 rate from 0x08", int'(stat_rate), 7);
    chk(stat_win == 1'b0, "R1 win from 0x08", int'(stat_win), 0);
    chk(wdog_rst == 1'b0, "R1 no pulse after reset", int'(wdog_rst), 0);
    check_cfg("R1");

    // R3 period for each rate, window off
    for (int r = 1; r <= 7; r++) begin
      do_reset({5'b00001, ~3'(r)}, 0);
      edges_to_pulse(4000, n);
      chk(n == period(r), "R3 period", n, period(r));
      @(negedge clk);
      chk(wdog_rst == 1'b0, "R3 one-cycle pulse", int'(wdog_rst), 0);
      edges_to_pulse(4000, n);
      chk(n == period(r) - 1, "R3 restart after timeout", n, period(r) - 1);
    end

    // R2 rate 0 is off; arm writes ignored
    do_reset(8'h07, 0);
    chk(stat_rate == 3'd0, "R2 rate zero", int'(stat_rate), 0);
    arm_write(8'h13);
    chk(wdog_rst == 1'b0, "R2 bad key ignored", int'(wdog_rst), 0);
    seen = 0;
    for (int i = 0; i < 2100; i++) begin
      @(negedge clk);
      if (wdog_rst) seen = 1;
    end
    chk(!seen, "R2 no timeout when off", int'(seen), 0);

    // R9 refresh restarts count (rate 2, P=32, window off)
    do_reset(8'h0D, 0);
    repeat (20) @(negedge clk);
    arm_write(8'h55);
    arm_write(8'hAA);
    chk(wdog_rst == 1'b0, "R9 no pulse on refresh", int'(wdog_rst), 0);
    edges_to_pulse(200, n);
    chk(n == 32, "R9 count restarted", n, 32);

    // R10 bad value, and 0xAA without 0x55
    do_reset(8'h0D, 0);
    repeat (3) @(negedge clk);
    arm_write(8'h12);
    chk(wdog_rst == 1'b1, "R10 wrong key", int'(wdog_rst), 1);
    do_reset(8'h0D, 0);
    repeat (3) @(negedge clk);
    arm_write(8'hAA);
    chk(wdog_rst == 1'b1, "R10 fire without arm", int'(wdog_rst), 1);
    do_reset(8'h0D, 0);
    arm_write(8'h55);
    arm_write(8'h3C);
    chk(wdog_rst == 1'b1, "R10 broken pair", int'(wdog_rst), 1);

    // R11 window: rate 2 window on (opt 0x05), opens at count 24
    do_reset(8'h05, 0);
    repeat (5) @(negedge clk);
    arm_write(8'h55); arm_write(8'hAA);
    chk(wdog_rst == 1'b1, "R11 early refresh", int'(wdog_rst), 1);
    do_reset(8'h05, 0);
    repeat (22) @(negedge clk);
    arm_write(8'h55); arm_write(8'hAA);
    chk(wdog_rst == 1'b1, "R11 one before window", int'(wdog_rst), 1);
    do_reset(8'h05, 0);
    repeat (23) @(negedge clk);
    arm_write(8'h55); arm_write(8'hAA);
    chk(wdog_rst == 1'b0, "R11 first window cycle", int'(wdog_rst), 0);
    edges_to_pulse(200, n);
    chk(n == 32, "R11 refresh in window restarts", n, 32);

    // R4 write once in normal mode
    do_reset(8'h0D, 0);
    ctl_write(8'h13, 0); check_cfg("R4 first write");
    ctl_write(8'h05, 0); check_cfg("R4 second write ignored");
    // R7 rate 0 consumes the write
    do_reset(8'h0D, 0);
    ctl_write(8'h00, 0); check_cfg("R7 zero rate kept");
    chk(stat_used == 1'b1, "R7 zero write consumed", int'(stat_used), 1);
    ctl_write(8'h16, 0); check_cfg("R7 later write ignored");
    // R8 window 0 consumes the write
    do_reset(8'h0D, 0);
    ctl_write(8'h01, 0); check_cfg("R8 window 0 kept");
    ctl_write(8'h10, 0);
    chk(stat_win == 1'b0, "R8 window locked off", int'(stat_win), 0);
    // R6 mask
    do_reset(8'h0D, 0);
    ctl_write(8'h16, 1); check_cfg("R6 masked write");
    chk(stat_used == 1'b0, "R6 mask not consumed", int'(stat_used), 0);
    // R5 special mode repeated writes
    do_reset(8'h0F, 1);
    ctl_write(8'h03, 0); ctl_write(8'h06, 0); ctl_write(8'h10, 0);
    check_cfg("R5 repeated special writes");
    chk(stat_rate == 3'd6, "R5 rate follows last", int'(stat_rate), 6);

    // random configuration traffic (R4 R5 R6 R7 R8)
    for (int it = 0; it < 50; it++) begin
      do_reset(8'($urandom), 1'($urandom));
      check_cfg("R1 random reset");
      for (int w = 0; w < 4; w++) begin
        ctl_write(8'($urandom), ($urandom % 3) == 0);
        check_cfg("R4/R5/R6 random write");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++; misses++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule